// File: doc/BRIEF.md
# Multichip NCO Phase Sync Controller

This block lines up the numerically controlled oscillators of several converter devices so that they all restart their phase at one shared instant. Every device carries one instance. A strap input selects the master or the slave role. The master turns a software request into a level on a shared general-purpose line. Each slave takes that line through a two-flop synchronizer and looks for its rising edge. A detected edge arms a pending flag. The flag fires on the next rising edge of the local multiframe boundary strobe (the LEMC strobe). This strobe has already been aligned across the devices, so every device reloads its oscillators at the same multiframe instant.

The master does not read the shared pin. It feeds its own line output back through the same synchronizer path. Its request therefore arms on the same cycle as the slaves, and it reloads on the same strobe edge. The oscillator bank holds one phase accumulator per up-converter channel and one per down-converter channel. On a qualified sync, each accumulator loads its own phase-offset word. At all other times it adds its frequency word on every clock.

A request is accepted only while the alignment-confirmed input is high. After the first qualified reload, a sticky done flag blocks further requests until software clears it.

Top module: `nco_phase_sync`

## Requirements
- R1: While reset is asserted, every `phaseOut` channel is 0, and `gpioOut` and `syncDone` are 0.
- R2: On a clock edge with no reload, every channel's `phaseOut` becomes its previous value plus its `freqWord`, modulo 2^ACC_W.
- R3: With `isMaster` high, `gpioOut` equals `syncRequest` as sampled on the previous edge. With `isMaster` low, `gpioOut` is 0. A master takes its sync line from its own `gpioOut` and ignores `gpioIn`.
- R4: A low-to-high transition of the selected sync line arms a pending sync only while `alignOk` is high and `syncDone` is low. A transition seen while `alignOk` is low never causes a reload.
- R5: A pending sync reloads on the first LEMC rising edge, meaning `lemcStrobe` is sampled 1 on an edge after being sampled 0 on the edge before. If the line is first sampled high on edge a, the earliest edge that can reload is a+3. A strobe rise on a+2 or earlier does not reload. After a reload, each `phaseOut` channel equals its `phaseOffset`.
- R6: All channels reload on the same edge. Indices 0..NUM_DUC-1 are the up-converter oscillators and the rest are the down-converter oscillators.
- R7: If a master first samples `syncRequest` high on edge m, the earliest reload is at a LEMC rise sampled on edge m+4. This matches a slave whose `gpioIn` is wired to the master's `gpioOut`.
- R8: `syncDone` goes to 1 on the reload edge and stays at 1. A `doneClear` sampled high clears it on that edge. While `syncDone` is 1, sync line edges are ignored.
- R9: A reload consumes the pending sync. Later LEMC rises, or a strobe held high, do not reload again without a new line edge.
- R10: A sync line held high through a `doneClear` does not count as a request. A fresh low-to-high transition is needed.
- R11: `alignOk` going low discards a pending sync, so no reload follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| isMaster | input | 1 | 1 selects the master role, 0 the slave role |
| alignOk | input | 1 | Multiframe alignment confirmed; enables sync acceptance |
| syncRequest | input | 1 | Master only: level driven onto the shared sync line |
| gpioIn | input | 1 | Shared sync line as received by a slave |
| gpioOut | output | 1 | Shared sync line driven by a master |
| lemcStrobe | input | 1 | Local multiframe boundary strobe |
| doneClear | input | 1 | Clears the sticky done flag |
| syncDone | output | 1 | Sticky flag: a qualified reload has happened |
| freqWord | input | NUM_CH*ACC_W | Per-channel phase increment |
| phaseOffset | input | NUM_CH*ACC_W | Per-channel phase loaded at a sync |
| phaseOut | output | NUM_CH*ACC_W | Per-channel phase accumulator value |

## Verification
The bench places a strobe rise two edges after the line is first sampled, where it must be rejected. It then holds the strobe high, where a level-sensitive design would reload. A rise exactly three edges after sampling must reload, and in master mode a rise four edges after the request must reload; an extra or missing flop in either path would move the reload off that edge. Further cases are a line edge while done is set, a line left high across a clear, and `alignOk` dropped while a sync is pending. A design that skipped the done, edge or alignment qualification would reload in one of these cases, and the reloaded phase would differ from the free-running value that the bench's reference model predicts every cycle.

// File: rtl/nps_pkg.sv
package nps_pkg;

  // Strobes passed from the sync control to the oscillator bank.
  typedef struct packed {
    logic ncoLoad;   // load phase offsets on this edge
  } ctlStrobe_t;

endpackage

// File: rtl/nps_edge_sync.sv
// Multi-flop synchronizer followed by a rising-edge detector.
module nps_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lineIn,
  output logic lineRise
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe <= {pipe[PIPE_W-2:0], lineIn};
    end
  end

  // Synchronized value is pipe[SYNC_STAGES-1]; the extra flop holds its prior value.
  assign lineRise = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];

endmodule

// File: rtl/nps_sync_ctrl.sv
// Role handling, request qualification, LEMC edge timing and done flag.
module nps_sync_ctrl
  import nps_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       isMaster,
  input  logic       alignOk,
  input  logic       syncRequest,
  input  logic       gpioIn,
  input  logic       lemcStrobe,
  input  logic       doneClear,
  output logic       gpioOut,
  output logic       syncDone,
  output ctlStrobe_t ctl
);
  logic gpioOutQ;
  logic lineSel;
  logic lineRise;
  logic lemcPrev;
  logic lemcRise;
  logic pending;
  logic doneQ;
  logic applyNow;

  // Master drives the shared line from the software request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gpioOutQ <= 1'b0;
    else        gpioOutQ <= isMaster & syncRequest;
  end

  // Master loops its own output back so its latency matches the slaves.
  assign lineSel = isMaster ? gpioOutQ : gpioIn;

  nps_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_lineSync (
    .clk     (clk),
    .rst_n   (rst_n),
    .lineIn  (lineSel),
    .lineRise(lineRise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lemcPrev <= 1'b0;
    else        lemcPrev <= lemcStrobe;
  end

  assign lemcRise = lemcStrobe & ~lemcPrev;
  assign applyNow = pending & lemcRise & alignOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (!alignOk) begin
      pending <= 1'b0;
    end else if (applyNow) begin
      pending <= 1'b0;
    end else if (lineRise && !doneQ) begin
      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doneQ <= 1'b0;
    end else if (applyNow) begin
      doneQ <= 1'b1;
    end else if (doneClear) begin
      doneQ <= 1'b0;
    end
  end

  assign gpioOut     = gpioOutQ;
  assign syncDone    = doneQ;
  assign ctl.ncoLoad = applyNow;

endmodule

// File: rtl/nps_nco_bank.sv
// One phase accumulator per converter channel.
module nps_nco_bank
  import nps_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ACC_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  ctlStrobe_t                   ctl,
  input  logic [NUM_CH-1:0][ACC_W-1:0] freqWord,
  input  logic [NUM_CH-1:0][ACC_W-1:0] phaseOffset,
  output logic [NUM_CH-1:0][ACC_W-1:0] phaseOut
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_acc
    logic [ACC_W-1:0] acc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc <= '0;
      end else if (ctl.ncoLoad) begin
        acc <= phaseOffset[ch];
      end else begin
        acc <= ACC_W'(acc + freqWord[ch]);
      end
    end

    assign phaseOut[ch] = acc;
  end

endmodule

// File: rtl/nco_phase_sync.sv
module nco_phase_sync
  import nps_pkg::*;
#(
  parameter int NUM_DUC     = 2,
  parameter int NUM_DDC     = 2,
  parameter int ACC_W       = 32,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_CH     = NUM_DUC + NUM_DDC
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         isMaster,
  input  logic                         alignOk,
  input  logic                         syncRequest,
  input  logic                         gpioIn,
  output logic                         gpioOut,
  input  logic                         lemcStrobe,
  input  logic                         doneClear,
  output logic                         syncDone,
  input  logic [NUM_CH-1:0][ACC_W-1:0] freqWord,
  input  logic [NUM_CH-1:0][ACC_W-1:0] phaseOffset,
  output logic [NUM_CH-1:0][ACC_W-1:0] phaseOut
);
  ctlStrobe_t ctl;

  nps_sync_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .isMaster   (isMaster),
    .alignOk    (alignOk),
    .syncRequest(syncRequest),
    .gpioIn     (gpioIn),
    .lemcStrobe (lemcStrobe),
    .doneClear  (doneClear),
    .gpioOut    (gpioOut),
    .syncDone   (syncDone),
    .ctl        (ctl)
  );

  nps_nco_bank #(
    .NUM_CH(NUM_CH),
    .ACC_W (ACC_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .freqWord   (freqWord),
    .phaseOffset(phaseOffset),
    .phaseOut   (phaseOut)
  );

endmodule

// File: rtl/nco_phase_sync_chk.sv
module nco_phase_sync_chk #(
  parameter int NUM_CH = 4,
  parameter int ACC_W  = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         isMaster,
  input logic                         alignOk,
  input logic                         lemcStrobe,
  input logic                         doneClear,
  input logic                         gpioOut,
  input logic                         syncDone,
  input logic                         ncoLoad,
  input logic [NUM_CH-1:0][ACC_W-1:0] freqWord,
  input logic [NUM_CH-1:0][ACC_W-1:0] phaseOffset,
  input logic [NUM_CH-1:0][ACC_W-1:0] phaseOut
);
  // R3: a slave never drives the shared line
  a_r3_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !isMaster |=> !gpioOut);

  // R4: no reload while alignment is not confirmed
  a_r4_no_load_unaligned: assert property (@(posedge clk) disable iff (!rst_n)
    !alignOk |=> !$rose(syncDone));

  // R5: done only rises right after a strobe rising edge
  a_r5_lemc_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncDone) |-> ($past(lemcStrobe) && !$past(lemcStrobe, 2)));

  // R6: every channel holds its offset right after the reload
  a_r6_all_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncDone) |-> (phaseOut == $past(phaseOffset)));

  // R8: done is sticky until cleared, and a clear takes effect
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (syncDone && !doneClear) |=> syncDone);

  a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (syncDone && doneClear) |=> !syncDone);

  // R2: free running advance on each channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_adv
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
      !ncoLoad |=> (phaseOut[g] == ACC_W'($past(phaseOut[g]) + $past(freqWord[g]))));
  end

endmodule

bind nco_phase_sync nco_phase_sync_chk #(
  .NUM_CH(NUM_CH),
  .ACC_W (ACC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .isMaster   (isMaster),
  .alignOk    (alignOk),
  .lemcStrobe (lemcStrobe),
  .doneClear  (doneClear),
  .gpioOut    (gpioOut),
  .syncDone   (syncDone),
  .ncoLoad    (ctl.ncoLoad),
  .freqWord   (freqWord),
  .phaseOffset(phaseOffset),
  .phaseOut   (phaseOut)
);

// File: tb/nco_phase_sync_test.sv
`timescale 1ns/1ps
module nco_phase_sync_test;
  localparam int NUM_DUC = 2;
  localparam int NUM_DDC = 2;
  localparam int NUM_CH  = NUM_DUC + NUM_DDC;
  localparam int ACC_W   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic isMaster = 1'b0, alignOk = 1'b0, syncRequest = 1'b0, gpioIn = 1'b0;
  logic lemcStrobe = 1'b0, doneClear = 1'b0;
  logic gpioOut, syncDone;
  logic [NUM_CH-1:0][ACC_W-1:0] freqWord, phaseOffset, phaseOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nco_phase_sync #(.NUM_DUC(NUM_DUC), .NUM_DDC(NUM_DDC), .ACC_W(ACC_W)) uut (
    .clk(clk), .rst_n(rst_n), .isMaster(isMaster), .alignOk(alignOk),
    .syncRequest(syncRequest), .gpioIn(gpioIn), .gpioOut(gpioOut),
    .lemcStrobe(lemcStrobe), .doneClear(doneClear), .syncDone(syncDone),
    .freqWord(freqWord), .phaseOffset(phaseOffset), .phaseOut(phaseOut)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- behavioural reference model ----------------
  logic [ACC_W-1:0] mAcc [NUM_CH];
  bit mPend, mDone, mGpioOut, mLemcPrev;
  bit lineHist[$];
  bit lRise, apply, src, reqRise;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) mAcc[i] = '0;
      mPend = 0; mDone = 0; mGpioOut = 0; mLemcPrev = 0;
      lineHist = '{0, 0, 0};
    end else begin
      lRise   = lemcStrobe && !mLemcPrev;
      apply   = mPend && lRise && alignOk;
      src     = isMaster ? mGpioOut : gpioIn;
      // lineHist[k] is the line as sampled k+1 edges ago
      reqRise = lineHist[1] && !lineHist[2];
      for (int i = 0; i < NUM_CH; i++)
        mAcc[i] = apply ? phaseOffset[i] : ACC_W'(mAcc[i] + freqWord[i]);
      if (!alignOk)                mPend = 0;
      else if (apply)              mPend = 0;
      else if (reqRise && !mDone)  mPend = 1;
      if (apply)          mDone = 1;
      else if (doneClear) mDone = 0;
      mGpioOut  = isMaster && syncRequest;
      mLemcPrev = lemcStrobe;
      lineHist.push_front(src);
      void'(lineHist.pop_back());
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int i = 0; i < NUM_CH; i++)
        chk(phaseOut[i] == mAcc[i], $sformatf("R2 model phase ch%0d", i), phaseOut[i], mAcc[i]);
      chk(syncDone == mDone, "R8 model syncDone", syncDone, mDone);
      chk(gpioOut == mGpioOut, "R3 model gpioOut", gpioOut, mGpioOut);
    end
  end

  task automatic expectLoaded(input string req);
    for (int i = 0; i < NUM_CH; i++)
      chk(phaseOut[i] == phaseOffset[i], $sformatf("%s offset ch%0d", req, i), phaseOut[i], phaseOffset[i]);
    chk(syncDone == 1'b1, {req, " done set"}, syncDone, 1);
  endtask

  initial begin
    freqWord[0] = 32'h0100_0000; phaseOffset[0] = 32'h1111_1111;
    freqWord[1] = 32'hF000_0001; phaseOffset[1] = 32'hDEAD_0000;
    freqWord[2] = 32'h0000_1234; phaseOffset[2] = 32'h0000_0000;
    freqWord[3] = 32'h8000_0000; phaseOffset[3] = 32'h7FFF_FFFF;

    step(3);
    for (int i = 0; i < NUM_CH; i++)
      chk(phaseOut[i] == '0, "R1 reset phase", phaseOut[i], 0);
    chk(gpioOut == 1'b0, "R1 reset gpioOut", gpioOut, 0);
    chk(syncDone == 1'b0, "R1 reset syncDone", syncDone, 0);

    rst_n = 1'b1;
    step(5);
    for (int i = 0; i < NUM_CH; i++)
      chk(phaseOut[i] == ACC_W'(freqWord[i] * 32'd5), "R2 free run 5 cycles", phaseOut[i], ACC_W'(freqWord[i] * 32'd5));

    // R4: line edge while alignment not confirmed
    alignOk = 0; gpioIn = 1; step(4);
    lemcStrobe = 1; step(1); lemcStrobe = 0; step(1);
    chk(syncDone == 1'b0, "R4 unaligned edge ignored", syncDone, 0);
    gpioIn = 0; alignOk = 1; step(4);

    // R5 early rise, R9 held level, then a valid rise
    gpioIn = 1; step(2);
    lemcStrobe = 1; step(1);
    chk(syncDone == 1'b0, "R5 rise at a+2 rejected", syncDone, 0);
    step(3);
    chk(syncDone == 1'b0, "R9 held strobe level no load", syncDone, 0);
    lemcStrobe = 0; step(1);
    lemcStrobe = 1; step(1);
    expectLoaded("R6");
    step(1);
    for (int i = 0; i < NUM_CH; i++)
      chk(phaseOut[i] == ACC_W'(phaseOffset[i] + freqWord[i]), "R2 advance after load", phaseOut[i], ACC_W'(phaseOffset[i] + freqWord[i]));
    lemcStrobe = 0; step(2);
    lemcStrobe = 1; step(1);
    lemcStrobe = 0;
    for (int i = 0; i < NUM_CH; i++)
      chk(phaseOut[i] == ACC_W'(phaseOffset[i] + freqWord[i] * 32'd4), "R9 no second load", phaseOut[i], ACC_W'(phaseOffset[i] + freqWord[i] * 32'd4));

    // R8: new edge while done is ignored
    gpioIn = 0; step(4); gpioIn = 1; step(4);
    lemcStrobe = 1; step(1); lemcStrobe = 0; step(1);
    chk(syncDone == 1'b1, "R8 done stays set", syncDone, 1);
    doneClear = 1; step(1); doneClear = 0;
    chk(syncDone == 1'b0, "R8 clear", syncDone, 0);

    // R10: line still high, no fresh edge
    step(4);
    lemcStrobe = 1; step(1); lemcStrobe = 0; step(1);
    chk(syncDone == 1'b0, "R10 held line not a request", syncDone, 0);

    // R5 earliest legal rise at a+3
    gpioIn = 0; step(4);
    gpioIn = 1; step(3);
    lemcStrobe = 1; step(1);
    expectLoaded("R5");
    lemcStrobe = 0;
    doneClear = 1; step(1); doneClear = 0;

    // R11: alignment lost while pending
    gpioIn = 0; step(4);
    gpioIn = 1; step(4);
    alignOk = 0; step(1); alignOk = 1; step(2);
    lemcStrobe = 1; step(1); lemcStrobe = 0; step(1);
    chk(syncDone == 1'b0, "R11 pending discarded", syncDone, 0);

    // R3: master ignores gpioIn
    gpioIn = 0; isMaster = 1; step(3);
    chk(gpioOut == 1'b0, "R3 master idle line", gpioOut, 0);
    gpioIn = 1; step(4);
    lemcStrobe = 1; step(1); lemcStrobe = 0; step(1);
    chk(syncDone == 1'b0, "R3 master ignores gpioIn", syncDone, 0);

    // R7: master request, reload at m+4
    syncRequest = 1; step(1);
    chk(gpioOut == 1'b1, "R3 master drives line", gpioOut, 1);
    step(3);
    lemcStrobe = 1; step(1);
    expectLoaded("R7");
    lemcStrobe = 0; syncRequest = 0; isMaster = 0; step(1);
    chk(gpioOut == 1'b0, "R3 slave line low", gpioOut, 0);
    step(5);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule